// File: doc/BRIEF.md
# Carry-Save Radix-2^k Montgomery Multiplier

This block computes the Montgomery product P = A·B·2^(-W) mod N for W-bit operands and an odd modulus N. It handles K bits of B per clock, starting from the least significant digit. The running partial sum is kept as a pair of vectors whose sum is its value. Each step folds in A·B_i and Q_i·M through two stacked 3:2 compressor layers, which form a 4-2 compressor. This keeps every loop step free of a long carry chain. M is the premultiplied modulus N·((-N^-1) mod 2^K), which the caller supplies.

Because M ≡ -1 (mod 2^K), the quotient digit Q_i is just the low K bits of the partial sum after A·B_i is added. No division, table or extra multiply is needed. The two vectors are added once, after the last digit. Whole multiples of N are then removed one per cycle until the value is below N. A caller raises `start` for one cycle with the operands valid, waits for the `done` pulse, and reads `p`.

Top module: `montgomery_csa`

## Requirements
- R1: While reset is asserted and after its release with no start, `done` is 0 and `p` is 0.
- R2: With N odd, A < N, B < N and `nt` = N·((-N^-1) mod 2^K), the product `p` presented with `done` equals A·B·2^(-W) mod N.
- R3: The value on `p` when `done` is high is always strictly below N, including the cases where the resolved sum exceeds N by several multiples.
- R4: `done` is high for exactly one cycle per operation, and `p` keeps its value after that until the next operation completes.
- R5: `done` rises between W/K+2 and W/K+1+2^K clock edges after the edge that samples `start` (W/K digit steps, one resolve, at least one final compare).
- R6: `start` and all operand inputs are ignored while an operation is in progress, so the result belongs to the operands sampled at the accepted start.
- R7: In every digit step, the low K bits of the compressed sum (partial sum + A·B_i + Q_i·M) add to zero modulo 2^K, so the right shift by K drops only zero bits. The carry out of those bits is carried into the next step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; sampled only while idle |
| a | input | W | Multiplicand A, below N |
| b | input | W | Multiplier B, below N, consumed K bits per step LSB first |
| n | input | W | Odd modulus N |
| nt | input | W+K | Premultiplied modulus N·((-N^-1) mod 2^K) |
| p | output | W | Montgomery product, valid from the `done` pulse |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that an accepted start carries an odd modulus. They also assume that A and B are below N and that `nt` is the matching premultiplied modulus. Under any other input the low-bit cancellation and the final-range property do not hold. The bench builds `nt` from N by searching the K-bit inverse, and every vector in its table keeps A and B below an odd N. The overlapped-start test changes the operands only while the block is busy.

// File: rtl/montgomery_csa.sv
module montgomery_csa #(
  parameter int W = 16,
  parameter int K = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] n,
  input  logic [W+K-1:0] nt,
  output logic [W-1:0] p,
  output logic         done
);
  localparam int STEPS = W / K;
  localparam int WS    = W + K + 1;
  localparam int WX    = WS + K;
  localparam int CW    = $clog2(STEPS + 1);

  typedef enum logic [1:0] {IDLE, LOOP, SUM, FIX} state_t;
  state_t st;

  logic [CW-1:0]  cnt;
  logic [W-1:0]   a_q, b_q, n_q;
  logic [W+K-1:0] nt_q;
  logic [WS-1:0]  s_q, c_q, r_q;
  logic           ci_q;

  logic [WX-1:0] s_x, c_x, ab_x, t_s, t_c, qn_x, u_s, u_c;
  logic [WX-2:0] maj1, maj2;
  logic [K-1:0]  q, low_sum;
  logic          cout;

  assign s_x  = {{K{1'b0}}, s_q};
  assign c_x  = {{K{1'b0}}, c_q};
  assign ab_x = {{(WX-W){1'b0}}, a_q} * {{(WX-K){1'b0}}, b_q[K-1:0]};

  assign t_s  = s_x ^ c_x ^ ab_x;
  assign maj1 = (s_x[WX-2:0] & c_x[WX-2:0]) | (s_x[WX-2:0] & ab_x[WX-2:0]) | (c_x[WX-2:0] & ab_x[WX-2:0]);
  assign t_c  = {maj1, ci_q};

  assign q    = t_s[K-1:0] + t_c[K-1:0];
  assign qn_x = {{(WX-W-K){1'b0}}, nt_q} * {{(WX-K){1'b0}}, q};

  assign u_s  = t_s ^ t_c ^ qn_x;
  assign maj2 = (t_s[WX-2:0] & t_c[WX-2:0]) | (t_s[WX-2:0] & qn_x[WX-2:0]) | (t_c[WX-2:0] & qn_x[WX-2:0]);
  assign u_c  = {maj2, 1'b0};

  assign low_sum = u_s[K-1:0] + u_c[K-1:0];
  assign cout    = |{u_s[K-1:0], u_c[K-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= IDLE;
      cnt  <= '0;
      a_q  <= '0;
      b_q  <= '0;
      n_q  <= '0;
      nt_q <= '0;
      s_q  <= '0;
      c_q  <= '0;
      ci_q <= 1'b0;
      r_q  <= '0;
      p    <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          a_q  <= a;
          b_q  <= b;
          n_q  <= n;
          nt_q <= nt;
          s_q  <= '0;
          c_q  <= '0;
          ci_q <= 1'b0;
          cnt  <= '0;
          st   <= LOOP;
        end
        LOOP: begin
          s_q  <= u_s[WX-1:K];
          c_q  <= u_c[WX-1:K];
          ci_q <= cout;
          b_q  <= b_q >> K;
          cnt  <= cnt + 1'b1;
          if (cnt == CW'(STEPS - 1)) st <= SUM;
        end
        SUM: begin
          r_q <= s_q + c_q + {{(WS-1){1'b0}}, ci_q};
          st  <= FIX;
        end
        FIX: begin
          if (r_q >= {{(WS-W){1'b0}}, n_q}) begin
            r_q <= r_q - {{(WS-W){1'b0}}, n_q};
          end else begin
            p    <= r_q[W-1:0];
            done <= 1'b1;
            st   <= IDLE;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  AST_N_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    (start && st == IDLE) |-> n[0]); // R2
  AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LOOP) |-> (low_sum == '0)); // R7
  AST_REDUCED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (p < n_q)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4
  AST_OPS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st != IDLE) |=> ($stable(n_q) && $stable(a_q) && $stable(nt_q))); // R6
endmodule

// File: tb/montgomery_csa_test.sv
module montgomery_csa_test;
  localparam int W = 16;
  localparam int K = 2;
  localparam int STEPS = W / K;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] a = '0, b = '0, n = '0;
  logic [W+K-1:0] nt = '0;
  logic [W-1:0] p;
  logic done;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  montgomery_csa #(.W(W), .K(K)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .a(a), .b(b), .n(n), .nt(nt),
    .p(p), .done(done)
  );

  localparam logic [47:0] VEC [8] = '{
    {16'd0,     16'd1234,  16'd40001},
    {16'd1,     16'd1,     16'd3},
    {16'd65534, 16'd65534, 16'd65535},
    {16'd0,     16'd0,     16'd1},
    {16'd12345, 16'd54321, 16'd65521},
    {16'd7,     16'd9,     16'd13},
    {16'd40000, 16'd1,     16'd40003},
    {16'd1000,  16'd2999,  16'd3001}
  };

  function automatic longint mont_ref(longint x, longint y, longint m);
    longint t = x * y;
    for (int i = 0; i < W; i++) begin
      if (t[0]) t = t + m;
      t = t >>> 1;
    end
    while (t >= m) t = t - m;
    return t;
  endfunction

  function automatic longint prem(longint m);
    for (int j = 0; j < (1 << K); j++)
      if (((m * j) + 1) % (1 << K) == 0) return m * j;
    return 0;
  endfunction

  task automatic check(string req, longint got, longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic run(input logic [W-1:0] xa, xb, xn, input bit overlap,
                     output longint res, output int lat);
    lat = 0;
    @(negedge clk);
    a = xa; b = xb; n = xn; nt = (W+K)'(prem(longint'(xn)));
    start = 1'b1;
    while (1) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (overlap && lat < 4) begin
        start = 1'b1; a = ~xa; b = xb ^ 16'h5a5a; n = 16'd7; nt = (W+K)'(prem(7));
      end else start = 1'b0;
      if (done) break;
      if (lat > 200) begin
        errors++;
        $display("FAIL watchdog: no done, got %0d expected <=%0d", lat, STEPS + 2 + (1 << K));
        break;
      end
    end
    start = 1'b0;
    res = longint'(p);
    lat = lat - 1;
  endtask

  initial begin
    longint res, exp;
    int lat;
    repeat (3) @(negedge clk);
    check("R1 done in reset", longint'(done), 0);
    check("R1 p in reset", longint'(p), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 done idle", longint'(done), 0);
    check("R1 p idle", longint'(p), 0);

    for (int v = 0; v < 8; v++) begin
      run(VEC[v][47:32], VEC[v][31:16], VEC[v][15:0], 1'b0, res, lat);
      exp = mont_ref(longint'(VEC[v][47:32]), longint'(VEC[v][31:16]), longint'(VEC[v][15:0]));
      check("R2 product", res, exp);
      check("R3 below N", longint'(res < longint'(VEC[v][15:0])), 1);
      check("R5 latency in range",
            longint'(lat >= STEPS + 2 && lat <= STEPS + 1 + (1 << K)), 1);
      @(negedge clk);
      check("R4 done one cycle", longint'(done), 0);
      repeat (3) @(negedge clk);
      check("R4 p held", longint'(p), exp);
    end

    run(16'd30000, 16'd29999, 16'd30011, 1'b1, res, lat);
    check("R6 busy start ignored", res, mont_ref(30000, 29999, 30011));

    run(16'd65520, 16'd65519, 16'd65521, 1'b0, res, lat);
    check("R3 R7 max operands", res, mont_ref(65520, 65519, 65521));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run timed out, got timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule